// File: doc/BRIEF.md
# Address-Space Tagged Translation Cache

This block is a small, fully associative cache of address translations. Each entry maps a 20-bit virtual page number to a 20-bit physical page number and carries the address-space identifier of the process that installed it. A lookup presents a virtual page number and the current address-space identifier. In the same cycle the block reports hit or miss and, on a hit, the physical page number. No array is indexed by the page number. Every entry compares its stored key with the one presented.

After a miss, the surrounding logic installs the missing translation through the fill port. When the current address space changes, entries that belong to other address spaces stay resident, so a switch back can reuse them. Three maintenance commands remove entries:
- drop one page of the current address space;
- drop every entry whose page number lies inside an inclusive range, whatever its address space;
- flush the whole table.

A maintenance command and a fill may arrive in the same cycle. The maintenance command takes effect first, and the fill then sees the slots it freed.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses and `lk_ppn` reads 0.
- R2: A lookup is combinational. `lk_hit` is 1 when a valid entry has a page number equal to `lk_vpn` and an identifier equal to `cur_asid`, and `lk_ppn` then carries that entry's physical page. On a miss `lk_ppn` is 0.
- R3: An entry whose identifier differs from `cur_asid` never produces a hit. Changing `cur_asid` removes nothing, so entries from other address spaces hit again once their identifier is current.
- R4: A fill (`fill_en`=1) installs `fill_vpn`→`fill_ppn` under `cur_asid`, and lookups see it from the next cycle on. If a valid entry already holds the same page number and identifier, that entry is overwritten in place: no duplicate is created and the replacement pointer does not move.
- R5: A new translation goes to the lowest-numbered invalid entry. When every entry is valid, it goes to the entry selected by a round-robin pointer. The pointer resets to 0 and advances by one, wrapping after the last entry, only when it has been used.
- R6: `mnt_op`=1 (page drop) invalidates the entry whose page number equals `mnt_lo` and whose identifier equals `cur_asid`. Entries of other address spaces are left alone.
- R7: `mnt_op`=2 (range drop) invalidates every entry with `mnt_lo` ≤ page number ≤ `mnt_hi`, whatever its identifier. Both bounds are included.
- R8: `mnt_op`=3 (flush) invalidates every entry. `mnt_op`=0 does nothing.
- R9: When a maintenance command and a fill occur in the same cycle, the command is applied first. The fill then chooses its slot, and looks for an existing match, among the entries that remain valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_asid | input | 8 | Identifier of the current address space (lookup, fill, page drop) |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_hit | output | 1 | Translation found |
| lk_ppn | output | 20 | Physical page number on a hit, 0 on a miss |
| fill_en | input | 1 | Install a translation this cycle |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 20 | Physical page number to install |
| mnt_op | input | 2 | 0 none, 1 page drop, 2 range drop, 3 flush |
| mnt_lo | input | 20 | Page to drop, or lower bound of the range |
| mnt_hi | input | 20 | Upper bound of the range |

## Verification
The hardest behaviour to reach is round-robin replacement. It needs a full table, a fill that matches no resident key under the current identifier, and a pointer position that can be told apart from the lowest free slot. The stimulus fills all four slots under one identifier, then installs a page under a second identifier to force the first eviction. Next it performs an in-place overwrite and a second eviction. The page that the second eviction removes shows whether the overwrite wrongly moved the pointer. Later steps combine range and page drops with fills in the same cycle, which shows that freed slots are reused at once.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    MNT_NONE  = 2'd0,
    MNT_PAGE  = 2'd1,
    MNT_RANGE = 2'd2,
    MNT_ALL   = 2'd3
  } mnt_op_e;
endpackage

// File: rtl/tlb_cam_match.sv
// Associative compare: one hit bit per valid entry whose key equals the probe.
module tlb_cam_match #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic [ENTRIES-1:0]             valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  tag_vpn,
  input  logic [ENTRIES-1:0][ASID_W-1:0] tag_asid,
  input  logic [VPN_W-1:0]               key_vpn,
  input  logic [ASID_W-1:0]              key_asid,
  output logic [ENTRIES-1:0]             hit_vec
);
  function automatic logic key_eq(input logic [VPN_W-1:0] a_v, input logic [ASID_W-1:0] a_s,
                                  input logic [VPN_W-1:0] b_v, input logic [ASID_W-1:0] b_s);
    return (a_v == b_v) && (a_s == b_s);
  endfunction

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = valid[i] && key_eq(tag_vpn[i], tag_asid[i], key_vpn, key_asid);
  end
endmodule

// File: rtl/tlb_kill_gen.sv
// Works out which entries a maintenance command removes.
module tlb_kill_gen #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 20
) (
  input  logic [1:0]                    mnt_op,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tag_vpn,
  input  logic [VPN_W-1:0]              mnt_lo,
  input  logic [VPN_W-1:0]              mnt_hi,
  input  logic [ENTRIES-1:0]            page_hit,
  output logic [ENTRIES-1:0]            kill_vec
);
  import tlb_pkg::*;

  function automatic logic in_span(input logic [VPN_W-1:0] v, input logic [VPN_W-1:0] lo,
                                   input logic [VPN_W-1:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

  logic [ENTRIES-1:0] span_vec;
  for (genvar i = 0; i < ENTRIES; i++) begin : g_span
    assign span_vec[i] = in_span(tag_vpn[i], mnt_lo, mnt_hi);
  end

  always_comb begin
    unique case (mnt_op)
      MNT_PAGE:  kill_vec = page_hit;
      MNT_RANGE: kill_vec = span_vec;
      MNT_ALL:   kill_vec = '1;
      default:   kill_vec = '0;
    endcase
  end
endmodule

// File: rtl/tlb_victim_sel.sv
// Chooses the slot a fill writes: existing key, then lowest free, then round-robin.
module tlb_victim_sel #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                fill_en,
  input  logic [ENTRIES-1:0]  valid_after,
  input  logic [ENTRIES-1:0]  fill_hit,
  input  logic [IDX_W-1:0]    rr_ptr,
  output logic [ENTRIES-1:0]  wr_oh,
  output logic                use_rr
);
  function automatic logic [ENTRIES-1:0] lowest_set(input logic [ENTRIES-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  logic [ENTRIES-1:0] free_vec;
  assign free_vec = ~valid_after;

  always_comb begin
    wr_oh  = '0;
    use_rr = 1'b0;
    if (fill_en) begin
      if (|fill_hit) begin
        wr_oh = fill_hit;
      end else if (|free_vec) begin
        wr_oh = lowest_set(free_vec);
      end else begin
        wr_oh[rr_ptr] = 1'b1;
        use_rr        = 1'b1;
      end
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [1:0]        mnt_op,
  input  logic [VPN_W-1:0]  mnt_lo,
  input  logic [VPN_W-1:0]  mnt_hi
);
  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
  logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
  logic [IDX_W-1:0]               rr_q;

  // named internal events, observed by the checker
  logic [ENTRIES-1:0] look_hit_vec;
  logic [ENTRIES-1:0] page_hit_vec;
  logic [ENTRIES-1:0] kill_vec;
  logic [ENTRIES-1:0] valid_after;
  logic [ENTRIES-1:0] fill_hit_vec;
  logic [ENTRIES-1:0] wr_oh;
  logic               use_rr;

  function automatic logic [IDX_W-1:0] rr_next(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(ENTRIES - 1)) ? '0 : p + 1'b1;
  endfunction

  tlb_cam_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_look (
    .valid(valid_q), .tag_vpn(vpn_q), .tag_asid(asid_q),
    .key_vpn(lk_vpn), .key_asid(cur_asid), .hit_vec(look_hit_vec)
  );

  tlb_cam_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_page (
    .valid(valid_q), .tag_vpn(vpn_q), .tag_asid(asid_q),
    .key_vpn(mnt_lo), .key_asid(cur_asid), .hit_vec(page_hit_vec)
  );

  tlb_kill_gen #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_kill (
    .mnt_op(mnt_op), .tag_vpn(vpn_q), .mnt_lo(mnt_lo), .mnt_hi(mnt_hi),
    .page_hit(page_hit_vec), .kill_vec(kill_vec)
  );

  // maintenance first: the fill sees only what survives it
  assign valid_after = valid_q & ~kill_vec;

  tlb_cam_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill (
    .valid(valid_after), .tag_vpn(vpn_q), .tag_asid(asid_q),
    .key_vpn(fill_vpn), .key_asid(cur_asid), .hit_vec(fill_hit_vec)
  );

  tlb_victim_sel #(.ENTRIES(ENTRIES)) u_vict (
    .fill_en(fill_en), .valid_after(valid_after), .fill_hit(fill_hit_vec),
    .rr_ptr(rr_q), .wr_oh(wr_oh), .use_rr(use_rr)
  );

  always_comb begin
    lk_ppn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (look_hit_vec[i]) lk_ppn = lk_ppn | ppn_q[i];
    end
  end
  assign lk_hit = |look_hit_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
      vpn_q   <= '0;
      asid_q  <= '0;
      ppn_q   <= '0;
    end else begin
      valid_q <= valid_after | wr_oh;
      if (use_rr) rr_q <= rr_next(rr_q);
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_oh[i]) begin
          vpn_q[i]  <= fill_vpn;
          asid_q[i] <= cur_asid;
          ppn_q[i]  <= fill_ppn;
        end
      end
    end
  end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int ENTRIES = 4,
  parameter int PPN_W   = 20,
  parameter int IDX_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fill_en,
  input logic [1:0]         mnt_op,
  input logic               lk_hit,
  input logic [PPN_W-1:0]   lk_ppn,
  input logic [ENTRIES-1:0] look_hit_vec,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] valid_after,
  input logic [ENTRIES-1:0] wr_oh,
  input logic [IDX_W-1:0]   rr_q,
  input logic               use_rr
);
  import tlb_pkg::*;

  AST_MISS_PPN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> lk_ppn == '0); // R2
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> valid_q != '0); // R2
  AST_NO_DUP_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_hit_vec)); // R4
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> valid_q != '0); // R4
  AST_ONE_SLOT_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_oh)); // R5
  AST_RR_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    use_rr |-> valid_after == '1); // R5
  AST_RR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !use_rr |=> $stable(rr_q)); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (mnt_op == MNT_ALL && !fill_en) |=> valid_q == '0); // R8
  AST_FLUSH_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (mnt_op == MNT_ALL && fill_en) |=> $countones(valid_q) == 1); // R9
endmodule

bind asid_tlb asid_tlb_chk #(.ENTRIES(ENTRIES), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .mnt_op(mnt_op),
  .lk_hit(lk_hit), .lk_ppn(lk_ppn), .look_hit_vec(look_hit_vec),
  .valid_q(valid_q), .valid_after(valid_after), .wr_oh(wr_oh),
  .rr_q(rr_q), .use_rr(use_rr)
);

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 34;

  typedef struct packed {
    logic [7:0]  rq;
    logic [7:0]  asid;
    logic        fe;
    logic [19:0] fv;
    logic [19:0] fp;
    logic [1:0]  op;
    logic [19:0] lo;
    logic [19:0] hi;
    logic [19:0] lv;
    logic        eh;
    logic [19:0] ep;
  } vec_t;

  // Each step: the lookup is checked against state left by earlier steps,
  // then the fill/maintenance of the step commits at the next clock edge.
  localparam vec_t VECS [NV] = '{
    '{8'd1, 8'd1, 1'b0, 20'h00000, 20'h00000, 2'd0, 20'h0, 20'h0, 20'h00000, 1'b0, 20'h00000}, // R1 empty
    '{8'd4, 8'd1, 1'b1, 20'h00000, 20'h00001, 2'd0, 20'h0, 20'h0, 20'h00000, 1'b0, 20'h00000}, // R4 not yet
    '{8'd2, 8'd1, 1'b1, 20'h00001, 20'h00010, 2'd0, 20'h0, 20'h0, 20'h00000, 1'b1, 20'h00001}, // R2
    '{8'd2, 8'd1, 1'b1, 20'h00002, 20'h00003, 2'd0, 20'h0, 20'h0, 20'h00001, 1'b1, 20'h00010}, // R2
    '{8'd2, 8'd1, 1'b1, 20'hFFFFF, 20'h00000, 2'd0, 20'h0, 20'h0, 20'h00002, 1'b1, 20'h00003}, // R2
    '{8'd2, 8'd1, 1'b0, 20'h00000, 20'h00000, 2'd0, 20'h0, 20'h0, 20'hFFFFF, 1'b1, 20'h00000}, // R2 ppn 0
    '{8'd3, 8'd2, 1'b0, 20'h00000, 20'h00000, 2'd0, 20'h0, 20'h0, 20'h00000, 1'b0, 20'h00000}, // R3
    '{8'd3, 8'd2, 1'b1, 20'h00000, 20'h0ABCD, 2'd0, 20'h0, 20'h0, 20'h00001, 1'b0, 20'h00000}, // R3 evicts slot0
    '{8'd5, 8'd1, 1'b0, 20'h00000, 20'h00000, 2'd0, 20'h0, 20'h0, 20'h00000, 1'b0, 20'h00000}, // R5 evicted
    '{8'd3, 8'd2, 1'b0, 20'h00000, 20'h00000, 2'd0, 20'h0, 20'h0, 20'h00000, 1'b1, 20'h0ABCD}, // R3
    '{8'd4, 8'd1, 1'b1, 20'h00001, 20'h01111, 2'd0, 20'h0, 20'h0, 20'h00001, 1'b1, 20'h00010}, // R4 overwrite
    '{8'd4, 8'd1, 1'b0, 20'h00000, 20'h00000, 2'd0, 20'h0, 20'h0, 20'h00001, 1'b1, 20'h01111}, // R4
    '{8'd5, 8'd1, 1'b1, 20'h00005, 20'h00055, 2'd0, 20'h0, 20'h0, 20'h00002, 1'b1, 20'h00003}, // R5 evicts slot1
    '{8'd5, 8'd1, 1'b0, 20'h00000, 20'h00000, 2'd0, 20'h0, 20'h0, 20'h00001, 1'b0, 20'h00000}, // R5
    '{8'd5, 8'd1, 1'b0, 20'h00000, 20'h00000, 2'd0, 20'h0, 20'h0, 20'h00002, 1'b1, 20'h00003}, // R5
    '{8'd6, 8'd1, 1'b0, 20'h00000, 20'h00000, 2'd1, 20'h5, 20'h0, 20'h00005, 1'b1, 20'h00055}, // R6
    '{8'd6, 8'd1, 1'b0, 20'h00000, 20'h00000, 2'd0, 20'h0, 20'h0, 20'h00005, 1'b0, 20'h00000}, // R6
    '{8'd6, 8'd1, 1'b0, 20'h00000, 20'h00000, 2'd1, 20'h0, 20'h0, 20'h00000, 1'b0, 20'h00000}, // R6 other id
    '{8'd6, 8'd2, 1'b0, 20'h00000, 20'h00000, 2'd0, 20'h0, 20'h0, 20'h00000, 1'b1, 20'h0ABCD}, // R6 kept
    '{8'd5, 8'd1, 1'b1, 20'h00007, 20'h00077, 2'd0, 20'h0, 20'h0, 20'h00007, 1'b0, 20'h00000}, // R5 free slot
    '{8'd7, 8'd1, 1'b0, 20'h00000, 20'h00000, 2'd2, 20'h1, 20'h7, 20'h00007, 1'b1, 20'h00077}, // R7
    '{8'd7, 8'd1, 1'b0, 20'h00000, 20'h00000, 2'd0, 20'h0, 20'h0, 20'h00007, 1'b0, 20'h00000}, // R7 hi bound
    '{8'd7, 8'd1, 1'b0, 20'h00000, 20'h00000, 2'd0, 20'h0, 20'h0, 20'h00002, 1'b0, 20'h00000}, // R7
    '{8'd7, 8'd1, 1'b0, 20'h00000, 20'h00000, 2'd0, 20'h0, 20'h0, 20'hFFFFF, 1'b1, 20'h00000}, // R7 above
    '{8'd7, 8'd2, 1'b0, 20'h00000, 20'h00000, 2'd0, 20'h0, 20'h0, 20'h00000, 1'b1, 20'h0ABCD}, // R7 below
    '{8'd9, 8'd1, 1'b1, 20'h00000, 20'h0C0DE, 2'd2, 20'h0, 20'h0, 20'h00000, 1'b0, 20'h00000}, // R9
    '{8'd7, 8'd2, 1'b0, 20'h00000, 20'h00000, 2'd0, 20'h0, 20'h0, 20'h00000, 1'b0, 20'h00000}, // R7 any id
    '{8'd9, 8'd1, 1'b0, 20'h00000, 20'h00000, 2'd0, 20'h0, 20'h0, 20'h00000, 1'b1, 20'h0C0DE}, // R9
    '{8'd9, 8'd1, 1'b1, 20'h00000, 20'h0BEEF, 2'd1, 20'h0, 20'h0, 20'hFFFFF, 1'b1, 20'h00000}, // R9
    '{8'd9, 8'd1, 1'b0, 20'h00000, 20'h00000, 2'd0, 20'h0, 20'h0, 20'h00000, 1'b1, 20'h0BEEF}, // R9
    '{8'd8, 8'd1, 1'b1, 20'h00009, 20'h00099, 2'd3, 20'h0, 20'h0, 20'h00000, 1'b1, 20'h0BEEF}, // R8
    '{8'd8, 8'd1, 1'b0, 20'h00000, 20'h00000, 2'd0, 20'h0, 20'h0, 20'h00000, 1'b0, 20'h00000}, // R8
    '{8'd9, 8'd1, 1'b0, 20'h00000, 20'h00000, 2'd0, 20'h0, 20'h0, 20'h00009, 1'b1, 20'h00099}, // R9
    '{8'd3, 8'd3, 1'b0, 20'h00000, 20'h00000, 2'd0, 20'h0, 20'h0, 20'h00009, 1'b0, 20'h00000}  // R3
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cur_asid = '0;
  logic [19:0] lk_vpn = '0;
  logic        lk_hit;
  logic [19:0] lk_ppn;
  logic        fill_en = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_ppn = '0;
  logic [1:0]  mnt_op = '0;
  logic [19:0] mnt_lo = '0;
  logic [19:0] mnt_hi = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asid_tlb u_asid_tlb (
    .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid), .lk_vpn(lk_vpn),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn), .fill_en(fill_en), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .mnt_op(mnt_op), .mnt_lo(mnt_lo), .mnt_hi(mnt_hi)
  );

  task automatic check_out(input int rq, input logic eh, input logic [19:0] ep, input int step);
    checks++;
    if (lk_hit !== eh || lk_ppn !== ep) begin
      errors++;
      $display("FAIL R%0d step %0d: hit=%0b ppn=%05h expected hit=%0b ppn=%05h",
               rq, step, lk_hit, lk_ppn, eh, ep);
    end
  endtask

  task automatic idle();
    fill_en = 1'b0;
    mnt_op  = 2'd0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cur_asid = VECS[i].asid;
      fill_en  = VECS[i].fe;
      fill_vpn = VECS[i].fv;
      fill_ppn = VECS[i].fp;
      mnt_op   = VECS[i].op;
      mnt_lo   = VECS[i].lo;
      mnt_hi   = VECS[i].hi;
      lk_vpn   = VECS[i].lv;
      #1;
      check_out(VECS[i].rq, VECS[i].eh, VECS[i].ep, i);
    end

    // R5: fill three more under id 1, then one more wraps through round-robin
    @(negedge clk); idle(); cur_asid = 8'd1;
    for (int k = 0; k < 3; k++) begin
      fill_en = 1'b1; fill_vpn = 20'h00100 + 20'(k); fill_ppn = 20'h00200 + 20'(k);
      @(negedge clk);
    end
    // table full: slot0=9, slot1..3 = 100..102; pointer is at 2
    fill_en = 1'b1; fill_vpn = 20'h00300; fill_ppn = 20'h00333;
    @(negedge clk); idle();
    lk_vpn = 20'h00101; #1; check_out(5, 1'b0, 20'h0, 100); // R5 slot2 replaced
    lk_vpn = 20'h00009; #1; check_out(5, 1'b1, 20'h00099, 101); // R5
    lk_vpn = 20'h00300; #1; check_out(5, 1'b1, 20'h00333, 102); // R5

    // R8: op 0 leaves everything in place
    mnt_op = 2'd0; mnt_lo = 20'h0; mnt_hi = 20'hFFFFF;
    @(negedge clk);
    lk_vpn = 20'h00102; #1; check_out(8, 1'b1, 20'h00202, 103); // R8 no-op

    // R1: reset mid-run empties the table
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    lk_vpn = 20'h00009; #1; check_out(1, 1'b0, 20'h0, 104); // R1
    lk_vpn = 20'h00300; #1; check_out(1, 1'b0, 20'h0, 105); // R1

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule